// File: doc/BRIEF.md
# Dual Token Bucket Ingress Policer

The block meters one ingress flow against two token buckets. The first is the committed bucket. The second is the peak/excess bucket. Each packet descriptor gives a length, a count-start offset and an incoming color. For each accepted descriptor the block decides a color (green, yellow or red), deducts that packet's cost from the bucket that covered it, and reports whether the packet passes or is dropped. The block is programmed through a small write-only register port.

Every rate, burst cap and the per-packet cost adjustment uses one scaled float-like code: a mantissa M and an exponent E, with value (1 + M/256)·2^E. Bucket levels carry eight fractional bits, so one token equals 256 internal units. The buckets refill on a periodic tick. The tick period is TICK_CYC clock cycles multiplied by 2^rdiv. A length mode ignores the packet length, so a fixed per-packet cost meters packets instead of bytes.

Top module: `dual_bucket_policer`

## Requirements
- R1: Reset state. Both buckets are unused (exponent 24, mantissa 0), both levels are 0, the algorithm is 2, the color mode is blind (3), and the actions are green pass, yellow pass, red drop. The adjust field is mantissa 256 with exponent 0, length mode is 0, and rdiv is 0. A packet sent after reset therefore comes out red and dropped.
- R2: A mantissa/exponent code (M, E) with E below 24 is worth (256+M)·2^E units. Any code with E of 24 or more is worth 0, which makes that bucket unused.
- R3: A bucket level never exceeds its burst cap. One cycle after any configuration write, both levels are reloaded to their full caps.
- R4: A refill tick fires once every TICK_CYC·2^rdiv cycles, counted from the last configuration write. Each tick adds the bucket's rate value to that bucket, saturating at the cap.
- R5: Packet cost in units is max(256·L + (adj_m − 256)·2^adj_e, 1). L is the packet length minus the offset, or 0 when the offset is not below the length.
- R6: With length mode set, L is 0. With adj_m = 384 and adj_e = 1, this gives exactly one token (256 units) per packet.
- R7: When the committed level is at least the cost, the packet is green and the cost is deducted from the committed bucket. Otherwise, when peak marking is on and the peak level covers the cost, the packet is yellow and the cost is deducted from the peak bucket. Otherwise the packet is red and nothing is deducted. Color codes are 0 green, 1 yellow, 2 red.
- R8: An algorithm value other than 2 disables the peak bucket, so no packet is yellow.
- R9: Color mode 3 is blind: the incoming color is ignored. In any other mode the block is color-aware. An incoming yellow packet cannot become green. An incoming red packet, or an incoming code 3, stays red.
- R10: Each color has a 2-bit action. Value 0 passes the packet, and any other value drops it.
- R11: pkt_ready is low during a configuration write cycle and during the reload cycle that follows it. An accepted descriptor produces exactly one result, with res_valid high on the next cycle. No result appears without an accepted descriptor.
- R12: Register map, by cfg_addr:
  - 0: committed rate; [7:0] mantissa, [12:8] exponent.
  - 1: committed burst, same layout.
  - 2: peak rate, same layout.
  - 3: peak burst, same layout.
  - 4: adjust; [8:0] mantissa, [13:9] exponent, [14] length mode.
  - 5: control; [1:0] algorithm, [3:2] color mode, [5:4] green action, [7:6] yellow action, [9:8] red action, [13:10] rdiv.
  - Writes to 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 15 | Register write data |
| pkt_valid | input | 1 | Descriptor valid |
| pkt_ready | output | 1 | Descriptor accepted when high with pkt_valid |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_ofs | input | LEN_W | Byte offset where counting starts |
| pkt_color | input | 2 | Incoming color (0 green, 1 yellow, 2 red) |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_color | output | 2 | Decided color |
| res_drop | output | 1 | 1 when the packet is dropped |

## Verification
A wrong bucket level cannot be seen directly. It shows up as a color that departs from a reference model, and only on the first packet whose cost lies between the wrong level and the correct one. The bench therefore sends packet sizes near the cap and the rate boundaries, so a level error surfaces within a few packets. A wrong tick period or a missed reload shifts the green-to-red boundary by whole ticks. Back-to-back packets right after configuration and after long idle gaps expose this within one tick period. The handshake and the one-cycle result latency can be checked on every cycle.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int LVL_W  = 36;  // bucket level, 8 fractional bits
  localparam int COST_W = 48;  // signed working width for packet cost
  localparam int CFG_W  = 15;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } color_e;

  typedef struct packed {
    logic [4:0] expo;
    logic [7:0] mant;
  } mexp_t;

  // (1 + m/256) * 2^e in 1/256 units; exponent 24 or above means unused
  function automatic logic [LVL_W-1:0] mexp_units(input mexp_t v);
    if (v.expo >= 5'd24) return '0;
    return LVL_W'({1'b1, v.mant}) << v.expo;
  endfunction

  // max(256*L + (am - 256) * 2^ae, 1) in 1/256 units
  function automatic logic [COST_W-1:0] pkt_cost(
      input logic [15:0] len, input logic [15:0] ofs, input logic lmode,
      input logic [8:0] am, input logic [4:0] ae);
    logic signed [COST_W-1:0] base, adj, sum;
    base = (lmode || (len <= ofs)) ? '0 : $signed(COST_W'(len - ofs) << 8);
    adj  = $signed(COST_W'(am)) - $signed(COST_W'(256));
    adj  = adj <<< ae;
    sum  = base + adj;
    if (sum < $signed(COST_W'(1))) return COST_W'(1);
    return $unsigned(sum);
  endfunction
endpackage

// File: rtl/dbp_tick_gen.sv
module dbp_tick_gen #(
  parameter int TICK_CYC = 500,
  parameter int RDIV_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [RDIV_W-1:0] rdiv,
  output logic              tick
);
  localparam int CNT_W = $clog2(TICK_CYC + 1) + (1 << RDIV_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(TICK_CYC) << rdiv;
  assign tick  = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                      cnt <= cnt + CNT_W'(1);
  end

  // R4: ticks never fire on adjacent cycles (period of at least two)
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R4: a configuration write restarts the period
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/dbp_bucket.sv
module dbp_bucket
  import dbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              tick,
  input  logic              charge_en,
  input  logic [COST_W-1:0] charge,
  input  logic [LVL_W-1:0]  cap,
  input  logic [LVL_W-1:0]  add,
  output logic [LVL_W-1:0]  level
);
  logic [LVL_W:0]   sum;
  logic [LVL_W-1:0] lvl_nxt;

  always_comb begin
    sum = {1'b0, level};
    if (charge_en) sum = sum - {1'b0, LVL_W'(charge)};
    if (tick)      sum = sum + {1'b0, add};
    lvl_nxt = (sum > {1'b0, cap}) ? cap : sum[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (reload) level <= cap;
    else             level <= lvl_nxt;
  end

  // R3: level stays under the cap outside the reload cycle
  p_below_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |-> (level <= cap));
  // R7: a charge is only requested when the level covers it
  p_charge_covered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    charge_en |-> (charge <= COST_W'(level)));
  // R4: without tick, charge or reload the level holds
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !tick && !charge_en) |=> (level == $past(level)));
endmodule

// File: rtl/dual_bucket_policer.sv
module dual_bucket_policer
  import dbp_pkg::*;
#(
  parameter int TICK_CYC = 500,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pkt_valid,
  output logic             pkt_ready,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [LEN_W-1:0] pkt_ofs,
  input  logic [1:0]       pkt_color,
  output logic             res_valid,
  output logic [1:0]       res_color,
  output logic             res_drop
);
  localparam int NB = 2;  // 0 committed, 1 peak
  localparam mexp_t UNUSED_ME = '{expo: 5'd24, mant: 8'd0};

  mexp_t       rate_q [NB];
  mexp_t       burst_q[NB];
  logic [8:0]  adj_m;
  logic [4:0]  adj_e;
  logic        lmode;
  logic [1:0]  algo, cmode, act_g, act_y, act_r;
  logic [3:0]  rdiv;
  logic        reload_q;

  // register port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        rate_q[i]  <= UNUSED_ME;
        burst_q[i] <= UNUSED_ME;
      end
      adj_m <= 9'd256; adj_e <= '0; lmode <= 1'b0;
      algo  <= 2'd2;   cmode <= 2'd3;
      act_g <= 2'd0;   act_y <= 2'd0; act_r <= 2'd1;
      rdiv  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: rate_q[0]  <= mexp_t'(cfg_wdata[12:0]);
        3'd1: burst_q[0] <= mexp_t'(cfg_wdata[12:0]);
        3'd2: rate_q[1]  <= mexp_t'(cfg_wdata[12:0]);
        3'd3: burst_q[1] <= mexp_t'(cfg_wdata[12:0]);
        3'd4: begin
          adj_m <= cfg_wdata[8:0]; adj_e <= cfg_wdata[13:9];
          lmode <= cfg_wdata[14];
        end
        3'd5: begin
          algo  <= cfg_wdata[1:0]; cmode <= cfg_wdata[3:2];
          act_g <= cfg_wdata[5:4]; act_y <= cfg_wdata[7:6];
          act_r <= cfg_wdata[9:8]; rdiv  <= cfg_wdata[13:10];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= 1'b0;
    else        reload_q <= cfg_we;
  end

  assign pkt_ready = !cfg_we && !reload_q;

  logic tick;
  dbp_tick_gen #(.TICK_CYC(TICK_CYC), .RDIV_W(4)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .rdiv(rdiv), .tick(tick));

  // decision
  logic              fire;
  logic [COST_W-1:0] cost;
  logic [LVL_W-1:0]  lvl [NB];
  logic [LVL_W-1:0]  cap [NB];
  logic              chg [NB];
  logic              c_cover, p_cover, peak_on;
  logic [1:0]        in_col;
  color_e            col;
  logic [1:0]        act_sel;

  assign fire    = pkt_valid && pkt_ready;
  assign cost    = pkt_cost(16'(pkt_len), 16'(pkt_ofs), lmode, adj_m, adj_e);
  assign peak_on = (algo == 2'd2);
  assign in_col  = (cmode == 2'd3) ? 2'd0 : pkt_color;
  assign c_cover = (cost <= COST_W'(lvl[0]));
  assign p_cover = peak_on && (cost <= COST_W'(lvl[1]));

  always_comb begin
    if (in_col == 2'd0 && c_cover)                        col = COL_GREEN;
    else if ((in_col == 2'd0 || in_col == 2'd1) && p_cover) col = COL_YELLOW;
    else                                                  col = COL_RED;
    case (col)
      COL_GREEN:  act_sel = act_g;
      COL_YELLOW: act_sel = act_y;
      default:    act_sel = act_r;
    endcase
  end

  assign chg[0] = fire && (col == COL_GREEN);
  assign chg[1] = fire && (col == COL_YELLOW);

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    assign cap[b] = mexp_units(burst_q[b]);
    dbp_bucket u_bkt (
      .clk(clk), .rst_n(rst_n), .reload(reload_q), .tick(tick),
      .charge_en(chg[b]), .charge(cost), .cap(cap[b]),
      .add(mexp_units(rate_q[b])), .level(lvl[b]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_color <= 2'd0; res_drop <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_color <= col;
        res_drop  <= (act_sel != 2'd0);
      end
    end
  end

  // R11: no acceptance while configuration is written
  p_no_accept_in_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !pkt_ready);
  // R11: one result per accepted descriptor, one cycle later
  p_result_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !res_valid);
  // R7: only legal color codes leave the block
  p_legal_color_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_color != 2'd3));
  // R8: peak bucket disabled means no yellow
  p_no_yellow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && algo != 2'd2) |-> (res_color != 2'd1));
  // R3: both buckets full right after the reload cycle
  p_full_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && !cfg_we) |=> (lvl[0] == cap[0] && lvl[1] == cap[1]));
endmodule

// File: tb/tb_dual_bucket_policer.sv
`timescale 1ns/1ps
module tb_dual_bucket_policer;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [14:0] cfg_wdata = '0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [15:0] pkt_len = '0, pkt_ofs = '0;
  logic [1:0]  pkt_color = '0;
  logic        res_valid, res_drop;
  logic [1:0]  res_color;

  always #2 clk = ~clk;

  dual_bucket_policer #(.TICK_CYC(TICK), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .pkt_ofs(pkt_ofs), .pkt_color(pkt_color),
    .res_valid(res_valid), .res_color(res_color), .res_drop(res_drop));

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int    m_rm[2], m_re[2], m_bm[2], m_be[2];
  int    m_am = 256, m_ae = 0, m_lm = 0, m_algo = 2, m_cm = 3;
  int    m_ag = 0, m_ay = 0, m_ar = 1, m_rdiv = 0;
  longint lv[2];
  int    tcnt = 0;
  bit    reload_m = 0;

  function automatic longint amt(int m, int e);
    if (e >= 24) return 0;
    return longint'(256 + m) * (longint'(1) << e);
  endfunction

  function automatic longint cost_of(int len, int ofs);
    longint l, c;
    l = (m_lm != 0 || len <= ofs) ? 0 : longint'(len - ofs);
    c = l * 256 + longint'(m_am - 256) * (longint'(1) << m_ae);
    return (c < 1) ? 1 : c;
  endfunction

  task automatic chk(string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic apply_cfg(int a, int d);
    case (a)
      0: begin m_rm[0] = d & 255; m_re[0] = (d >> 8) & 31; end
      1: begin m_bm[0] = d & 255; m_be[0] = (d >> 8) & 31; end
      2: begin m_rm[1] = d & 255; m_re[1] = (d >> 8) & 31; end
      3: begin m_bm[1] = d & 255; m_be[1] = (d >> 8) & 31; end
      4: begin m_am = d & 511; m_ae = (d >> 9) & 31; m_lm = (d >> 14) & 1; end
      5: begin
        m_algo = d & 3; m_cm = (d >> 2) & 3; m_ag = (d >> 4) & 3;
        m_ay = (d >> 6) & 3; m_ar = (d >> 8) & 3; m_rdiv = (d >> 10) & 15;
      end
      default: ;
    endcase
  endtask

  // one cycle: entered and left at a falling edge
  task automatic cyc(bit we, int a, int d, bit pv, int len, int ofs, int col);
    bit rdy, fire, tk;
    int ec, inc, act;
    longint c, add, nx;
    cfg_we = we; cfg_addr = 3'(a); cfg_wdata = 15'(d);
    pkt_valid = pv; pkt_len = 16'(len); pkt_ofs = 16'(ofs); pkt_color = 2'(col);
    #1;
    rdy = !we && !reload_m;
    chk("pkt_ready", pkt_ready, rdy);  // R11
    fire = pv && rdy;
    c = cost_of(len, ofs);
    inc = (m_cm == 3) ? 0 : col;
    if (inc == 0 && c <= lv[0]) ec = 0;
    else if ((inc == 0 || inc == 1) && m_algo == 2 && c <= lv[1]) ec = 1;
    else ec = 2;
    act = (ec == 0) ? m_ag : (ec == 1) ? m_ay : m_ar;
    tk = (tcnt == (TICK << m_rdiv) - 1);
    for (int b = 0; b < 2; b++) begin
      if (reload_m) lv[b] = amt(m_bm[b], m_be[b]);
      else begin
        nx = lv[b];
        if (fire && ec == b) nx = nx - c;
        add = amt(m_rm[b], m_re[b]);
        if (tk) nx = nx + add;
        if (nx > amt(m_bm[b], m_be[b])) nx = amt(m_bm[b], m_be[b]);
        lv[b] = nx;
      end
    end
    tcnt = (we || tk) ? 0 : tcnt + 1;
    reload_m = we;
    if (we) apply_cfg(a, d);
    @(posedge clk); @(negedge clk);
    chk("res_valid", res_valid, fire);
    if (fire) begin
      chk("res_color", res_color, ec);
      chk("res_drop", res_drop, act != 0);
    end
  endtask

  task automatic wr(int a, int d);  cyc(1, a, d, 0, 0, 0, 0); endtask
  task automatic pkt(int len, int ofs, int col); cyc(0, 0, 0, 1, len, ofs, col); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0); endtask

  function automatic int ctrl(int al, int cm, int g, int y, int r, int rd);
    return al | (cm << 2) | (g << 4) | (y << 6) | (r << 8) | (rd << 10);
  endfunction

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_rm[b] = 0; m_re[b] = 24; m_bm[b] = 0; m_be[b] = 24; lv[b] = 0;
    end
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, packet comes out red and dropped
    tag = "R1";
    chk("res_valid after reset", res_valid, 0);
    pkt(10, 0, 0);
    pkt(1, 0, 0);
    // R12 / R2: committed rate 256 B/tick, burst 1024 B
    tag = "R12";
    wr(0, 8 << 8); wr(1, 10 << 8); wr(5, ctrl(2, 3, 0, 0, 1, 0));
    tag = "R3";
    idle(1);
    for (int i = 0; i < 4; i++) pkt(600, 0, 0);
    // R4: refill up to the cap
    tag = "R4";
    idle(40);
    pkt(1024, 0, 0); pkt(1, 0, 0);
    idle(TICK - 3); pkt(256, 0, 0); pkt(256, 0, 0);
    wr(5, ctrl(2, 3, 0, 0, 1, 2));
    idle(TICK * 4 - 2); pkt(1024, 0, 0); pkt(200, 0, 0);
    idle(TICK * 4); pkt(300, 0, 0);
    // R5: negative adjust and offset beyond length
    tag = "R5";
    wr(4, 3 << 9);
    idle(2);
    pkt(5, 0, 0); pkt(3, 9, 0); pkt(40, 30, 0); pkt(2000, 0, 0);
    // R2 / R6: 3-token cap, zero rate, packet metering
    tag = "R6";
    wr(0, 24 << 8); wr(1, (1 << 8) | 128); wr(4, 384 | (1 << 9) | (1 << 14));
    idle(1);
    for (int i = 0; i < 5; i++) pkt(100 + 500 * i, 0, 0);
    tag = "R2";
    idle(50); pkt(9, 0, 0);
    // R7: both buckets in use
    tag = "R7";
    wr(4, 256); wr(0, 8 << 8); wr(1, 9 << 8); wr(2, 8 << 8); wr(3, 11 << 8);
    wr(5, ctrl(2, 3, 0, 0, 1, 0));
    idle(1);
    for (int i = 0; i < 9; i++) pkt(400, 0, 0);
    // R8: peak disabled
    tag = "R8";
    wr(5, ctrl(0, 3, 0, 0, 1, 0));
    idle(1);
    for (int i = 0; i < 9; i++) pkt(400, 0, 0);
    // R9: color-aware then blind
    tag = "R9";
    wr(5, ctrl(2, 0, 0, 0, 1, 0));
    idle(1);
    pkt(10, 0, 2); pkt(10, 0, 1); pkt(10, 0, 3); pkt(10, 0, 0);
    wr(5, ctrl(2, 3, 0, 0, 1, 0));
    idle(1);
    pkt(10, 0, 2); pkt(10, 0, 1);
    // R10: per-color actions
    tag = "R10";
    wr(5, ctrl(2, 3, 2, 0, 0, 0));
    idle(1);
    for (int i = 0; i < 8; i++) pkt(450, 0, 0);
    wr(5, ctrl(2, 3, 0, 3, 0, 0));
    idle(1);
    for (int i = 0; i < 8; i++) pkt(450, 0, 0);
    // R11: descriptors offered during write and reload are refused
    tag = "R11";
    cyc(1, 6, 0, 1, 10, 0, 0);
    pkt(10, 0, 0); pkt(10, 0, 0);
    cyc(1, 7, 12345, 0, 0, 0, 0); pkt(10, 0, 0); pkt(10, 0, 0);
    // R7: constrained random mix
    tag = "R7";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) begin
        int a, d;
        a = $urandom_range(0, 5);
        if (a < 4) d = ($urandom_range(0, 25) << 8) | $urandom_range(0, 255);
        else if (a == 4)
          d = $urandom_range(0, 511) | ($urandom_range(0, 10) << 9) |
              ($urandom_range(0, 1) << 14);
        else
          d = ctrl($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
        wr(a, d);
      end else if (r < 65) begin
        pkt($urandom_range(0, 2000),
            ($urandom_range(0, 9) == 0) ? $urandom_range(0, 3000) : $urandom_range(0, 64),
            $urandom_range(0, 3));
      end else idle(1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule